// File: doc/BRIEF.md
# Byte Stack with Non-Consuming Read Mode

This block is the operand stack of a small stack-machine processor. It holds bytes pushed by the execution unit and returns them in last-in, first-out order. A "keep" mode lets an instruction read its operands without removing them. The block does this with two counters: a read counter that pops move, and a write counter that pushes move.

Outside keep mode the two counters move together, and the block acts as an ordinary stack. In keep mode a pop lowers only the read counter, so the stored entries and the write counter do not change. Results are then pushed on top of the operands that were left in place. An end-of-instruction strobe copies the write counter into the read counter, which puts the stack back in step for the next instruction.

Reading below the bottom of the stack or writing past its top is an error. On either one, both counters return to zero and an error flag is raised. The flag stays set until it is cleared, and the sequencer uses it to trap. Within one instruction the sequencer must issue all its pops before any push. Pop and push must never be strobed in the same cycle. If they are, the pop is carried out and the push is dropped.

Top module: `dual_ptr_stack`

## Requirements
- R1: After reset, `depth_o` is 0 and `err_o` is 0.
- R2: A non-keep push stores `push_data_i` and raises `depth_o` by one. A non-keep pop lowers `depth_o` by one. The popped byte, which is the most recently pushed entry still present, appears on `pop_data_o` in the cycle after the pop strobe.
- R3: A keep-mode pop returns the entry below the read counter and leaves `depth_o` unchanged.
- R4: Successive keep-mode pops in one instruction return successively deeper entries. A keep-mode push stores its byte above the unchanged entries, at the write counter.
- R5: The end-of-instruction strobe sets the read counter equal to the write counter. The next pop after it therefore returns the top entry.
- R6: Duplicating a single stacked 00 in keep mode (keep pop, then two keep pushes of the read value) leaves depth 3, and every entry reads 00.
- R7: A pop with the read counter at 0 sets `err_o` and forces `depth_o` to 0.
- R8: The underflow check uses the read counter. With one entry stacked, a second keep-mode pop in the same instruction raises the error and forces depth 0.
- R9: The stack holds DEPTH entries. A push with `depth_o` equal to DEPTH raises the error and forces `depth_o` to 0 instead of wrapping. Later pushes then start from the bottom.
- R10: `err_o` stays at 1 until `err_clr_i` is asserted. It then reads 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pop_i | input | 1 | Pop strobe |
| push_i | input | 1 | Push strobe |
| push_data_i | input | DATA_W | Byte to push |
| keep_i | input | 1 | Keep mode for the current pop or push |
| eoi_i | input | 1 | End-of-instruction strobe; copies the write counter into the read counter |
| err_clr_i | input | 1 | Clears the error flag |
| pop_data_o | output | DATA_W | Popped byte, registered |
| depth_o | output | CNT_W | Write counter, which is the number of stored entries |
| err_o | output | 1 | Underflow or overflow flag, sticky |

## Verification
The bench compares normal-mode and keep-mode pops over the same contents. A design that moved the write counter on a keep pop would report a smaller depth, and its later pushes would overwrite the operands. After keep pops, the bench pops in normal mode across an instruction boundary; a design without the resync would return a deeper entry than the top. The bench then runs a keep-mode duplicate and a keep-mode add-style sequence and checks their exact results. At the edges it checks underflow through repeated keep pops, which a design that tested only the write counter would miss, and it fills the stack completely to catch overflow that wraps silently. It also holds the error flag across idle cycles before clearing it.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef struct packed {
    logic pop;
    logic push;
    logic keep;
    logic eoi;
  } stk_cmd_t;
endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Single write port, registered read port: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/stk_ptr_ctrl.sv
module stk_ptr_ctrl
  import stk_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_cmd_t          cmd,
  input  logic              err_clr,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [CNT_W-1:0]  wr_cnt,
  output logic              err,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] rd_nxt, wr_nxt, rd_dec, wr_inc;
  logic             err_set;

  assign rd_dec    = rd_cnt - ONE;
  assign wr_inc    = wr_cnt + ONE;
  assign mem_raddr = rd_dec[ADDR_W-1:0];
  assign mem_waddr = wr_cnt[ADDR_W-1:0];

  always_comb begin
    rd_nxt  = rd_cnt;
    wr_nxt  = wr_cnt;
    err_set = 1'b0;
    mem_we  = 1'b0;
    mem_re  = 1'b0;
    if (cmd.pop) begin
      // a push in the same cycle is dropped
      if (rd_cnt == '0) begin
        rd_nxt  = '0;
        wr_nxt  = '0;
        err_set = 1'b1;
      end else begin
        mem_re = 1'b1;
        rd_nxt = rd_dec;
        if (!cmd.keep) wr_nxt = rd_dec;
      end
    end else if (cmd.push) begin
      if (wr_cnt == FULL) begin
        rd_nxt  = '0;
        wr_nxt  = '0;
        err_set = 1'b1;
      end else begin
        mem_we = 1'b1;
        wr_nxt = wr_inc;
        if (!cmd.keep) rd_nxt = wr_inc;
      end
    end
    // instruction boundary: read counter rejoins the write counter
    if (cmd.eoi) rd_nxt = wr_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
      err    <= 1'b0;
    end else begin
      rd_cnt <= rd_nxt;
      wr_cnt <= wr_nxt;
      if (err_set)      err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_ptr_stack.sv
module dual_ptr_stack
  import stk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pop_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              keep_i,
  input  logic              eoi_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              err_o
);
  stk_cmd_t          cmd;
  logic [CNT_W-1:0]  rd_cnt, wr_cnt;
  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;

  assign cmd = '{pop: pop_i, push: push_i, keep: keep_i, eoi: eoi_i};

  stk_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .err_clr   (err_clr_i),
    .rd_cnt    (rd_cnt),
    .wr_cnt    (wr_cnt),
    .err       (err_o),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr)
  );

  stk_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (push_data_i),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (pop_data_o)
  );

  assign depth_o = wr_cnt;
endmodule

// File: rtl/dual_ptr_stack_chk.sv
module dual_ptr_stack_chk #(
  parameter int DEPTH = 256,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             pop_i,
  input logic             push_i,
  input logic             keep_i,
  input logic             eoi_i,
  input logic             err_clr_i,
  input logic [CNT_W-1:0] depth_o,
  input logic             err_o,
  input logic [CNT_W-1:0] rd_cnt,
  input logic [CNT_W-1:0] wr_cnt
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (depth_o == '0 && !err_o)); // R1

  AST_NORMAL_POP: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !keep_i && !push_i && rd_cnt != '0 && rd_cnt == wr_cnt)
      |=> depth_o == $past(depth_o) - 1'b1); // R2

  AST_KEEP_POP: assert property (@(posedge clk) disable iff (rst)
    (pop_i && keep_i && rd_cnt != '0) |=> $stable(depth_o)); // R3

  AST_RESYNC: assert property (@(posedge clk) disable iff (rst)
    eoi_i |=> rd_cnt == wr_cnt); // R5

  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pop_i && rd_cnt == '0) |=> (err_o && depth_o == '0)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && wr_cnt == CNT_W'(DEPTH)) |=> (err_o && depth_o == '0)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_o && !err_clr_i) |=> err_o); // R10

  always_comb begin
    if (!rst) AST_RD_NOT_ABOVE_WR: assert (rd_cnt <= wr_cnt); // R4
  end
endmodule

bind dual_ptr_stack dual_ptr_stack_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pop_i     (pop_i),
  .push_i    (push_i),
  .keep_i    (keep_i),
  .eoi_i     (eoi_i),
  .err_clr_i (err_clr_i),
  .depth_o   (depth_o),
  .err_o     (err_o),
  .rd_cnt    (rd_cnt),
  .wr_cnt    (wr_cnt)
);

// File: tb/dual_ptr_stack_bench.sv
module dual_ptr_stack_bench;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 256;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pop_i = 0, push_i = 0, keep_i = 0, eoi_i = 0, err_clr_i = 0;
  logic [DATA_W-1:0] push_data_i = '0;
  logic [DATA_W-1:0] pop_data_o;
  logic [CNT_W-1:0]  depth_o;
  logic              err_o;

  int total = 0;
  int bad   = 0;
  logic mon_en = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  dual_ptr_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dual_ptr_stack (
    .clk(clk), .rst(rst), .pop_i(pop_i), .push_i(push_i),
    .push_data_i(push_data_i), .keep_i(keep_i), .eoi_i(eoi_i),
    .err_clr_i(err_clr_i), .pop_data_o(pop_data_o), .depth_o(depth_o),
    .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit p, input bit u, input int d, input bit k, input bit e);
    pop_i = p; push_i = u; push_data_i = DATA_W'(d); keep_i = k; eoi_i = e;
    @(negedge clk);
    pop_i = 0; push_i = 0; keep_i = 0; eoi_i = 0;
  endtask

  task automatic push(input int d, input bit k, input bit e);
    cyc(0, 1, d, k, e);
  endtask

  // driver side of the scoreboard: queue the expected byte, then pop
  task automatic pop_exp(input int d, input bit k, input bit e, input string tag);
    exp_q.push_back(d);
    tag_q.push_back(tag);
    mon_en = 1'b1;
    cyc(1, 0, 0, k, e);
    mon_en = 1'b0;
  endtask

  task automatic clr_err();
    err_clr_i = 1'b1;
    @(negedge clk);
    err_clr_i = 1'b0;
  endtask

  // monitor: compare popped data one cycle after each scored pop
  initial begin
    forever begin
      bit hit;
      @(posedge clk);
      hit = pop_i && mon_en;
      @(negedge clk);
      if (hit) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(pop_data_o == DATA_W'(e), t, int'(pop_data_o), e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(depth_o == 0, "R1 depth", int'(depth_o), 0);
    chk(err_o == 0, "R1 err", int'(err_o), 0);

    // R2 normal push/pop
    push('hA1, 0, 1); push('hB2, 0, 1); push('hC3, 0, 1);
    chk(depth_o == 3, "R2 depth after pushes", int'(depth_o), 3);
    pop_exp('hC3, 0, 1, "R2 pop data");
    chk(depth_o == 2, "R2 depth after pop", int'(depth_o), 2);

    // R3/R4 keep pops leave depth, read deeper
    pop_exp('hB2, 1, 0, "R3 keep pop data");
    chk(depth_o == 2, "R3 depth kept", int'(depth_o), 2);
    pop_exp('hA1, 1, 0, "R4 second keep pop data");
    chk(depth_o == 2, "R4 depth kept", int'(depth_o), 2);
    cyc(0, 0, 0, 0, 1);
    // R5 resync: top returned again
    pop_exp('hB2, 0, 1, "R5 pop after resync");
    chk(depth_o == 1, "R5 depth", int'(depth_o), 1);
    pop_exp('hA1, 0, 1, "R5 bottom");

    // R6 keep-mode duplicate of 00
    push('h00, 0, 1);
    pop_exp('h00, 1, 0, "R6 keep read");
    push('h00, 1, 0);
    push('h00, 1, 1);
    chk(depth_o == 3, "R6 depth", int'(depth_o), 3);
    pop_exp('h00, 0, 1, "R6 entry2");
    pop_exp('h00, 0, 1, "R6 entry1");
    pop_exp('h00, 0, 1, "R6 entry0");

    // R4 keep-mode add: 03 04 -> 03 04 07
    push('h03, 0, 1); push('h04, 0, 1);
    pop_exp('h04, 1, 0, "R4 add b");
    pop_exp('h03, 1, 0, "R4 add a");
    push(('h03 + 'h04) & 'hFF, 1, 1);
    chk(depth_o == 3, "R4 add depth", int'(depth_o), 3);
    pop_exp('h07, 0, 1, "R4 add result");
    pop_exp('h04, 0, 1, "R4 add b kept");
    pop_exp('h03, 0, 1, "R4 add a kept");

    // R7 underflow, R10 sticky error
    chk(err_o == 0, "R7 no err before", int'(err_o), 0);
    cyc(1, 0, 0, 0, 1);
    chk(err_o == 1, "R7 err", int'(err_o), 1);
    chk(depth_o == 0, "R7 depth", int'(depth_o), 0);
    repeat (3) @(negedge clk);
    chk(err_o == 1, "R10 held", int'(err_o), 1);
    clr_err();
    chk(err_o == 0, "R10 cleared", int'(err_o), 0);

    // R8 keep-mode underflow via read counter
    push('h5A, 0, 1);
    pop_exp('h5A, 1, 0, "R8 first keep pop");
    chk(err_o == 0, "R8 no err yet", int'(err_o), 0);
    cyc(1, 0, 0, 1, 1);
    chk(err_o == 1, "R8 err", int'(err_o), 1);
    chk(depth_o == 0, "R8 depth", int'(depth_o), 0);
    clr_err();

    // R9 overflow
    for (int i = 0; i < DEPTH; i++) push(i & 'hFF, 0, 1);
    chk(depth_o == DEPTH, "R9 full depth", int'(depth_o), DEPTH);
    chk(err_o == 0, "R9 no err at full", int'(err_o), 0);
    push('hEE, 0, 1);
    chk(err_o == 1, "R9 err", int'(err_o), 1);
    chk(depth_o == 0, "R9 depth reset", int'(depth_o), 0);
    clr_err();
    push('h77, 0, 1);
    chk(depth_o == 1, "R9 restart depth", int'(depth_o), 1);
    pop_exp('h77, 0, 1, "R9 restart data");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule